// File: doc/BRIEF.md
# Shared External Bus Arbiter

This block decides who drives one shared external bus: an external host processor, or one of several on-chip masters (two DMA engines and a DRAM refresh requester by default). Each internal master presents a request and a priority level. The host presents a request and a programmable priority level. The arbiter compares these levels and moves through four ownership states: idle, host owns, internal waiting, and internal owns. It drives a grant line toward the host. It also drives an active-low bus-busy line with its own output enable, which it turns on only while an internal master holds the bus.

A change of owner from the host to an internal master always passes through a waiting state. In that state the grant is withdrawn, and the arbiter waits until the host releases the bus-busy line. While the host is in a locked read-modify-write sequence, the arbiter does not take the bus from it. A halt input leaves only DRAM refresh eligible among the internal masters. The internal master that wins is told so by a one-cycle pulse when it takes the bus.

Top module: `ext_bus_arbiter`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block enters idle after that edge: `ext_grant` = 0, `busy_oe` = 0, `busy_n_out` = 1 and `int_granted` = 0.
- R2: From idle, with no eligible internal request, a high `ext_req` sets `ext_grant` to 1 after the next edge. The grant stays at 1 while `ext_req` stays high and no internal master outranks the host.
- R3: When the host and internal masters request together from idle, an internal master whose level is strictly above `ext_prio` wins. If the levels are equal, or the host level is higher, the host is granted.
- R4: While the host owns the bus, `ext_grant` drops only when an eligible internal request has a level strictly above `ext_prio`. An internal request at an equal or lower level leaves the grant at 1.
- R5: While `locked` is high, the host keeps `ext_grant` even when an internal master outranks it. The handover starts at the first edge after `locked` falls.
- R6: After the grant is withdrawn, `ext_grant` and `busy_oe` both stay 0 for as long as `busy_in_n` is 0. At the first edge that samples `busy_in_n` = 1, internal ownership begins.
- R7: `busy_oe` = 1 with `busy_n_out` = 0 only while an internal master owns the bus. In every other state `busy_oe` = 0, and `busy_oe` and `ext_grant` are never both 1.
- R8: Internal ownership lasts while any eligible internal request is high. When none remains, the block goes to host-owns (`ext_grant` = 1) if `ext_req` is high, and otherwise to idle.
- R9: While an internal master owns the bus, the host takes it over only if `ext_prio` is strictly above the highest eligible internal level. When the levels are equal, the internal owner keeps the bus.
- R10: While `halt` is high, only the refresh requester (index `REFRESH_IDX`, default 2) is eligible, and DMA requests have no effect. An internal owner with no refresh request releases the bus at the next edge.
- R11: On entry to internal ownership, `int_granted` is one-hot on the winning index for exactly one cycle. Among equal internal levels, the lower index wins. `int_prio` holds level k in bits [k*PW +: PW].
- R12: If the host drops `ext_req` while it owns the bus and no internal master is eligible, `ext_grant` goes to 0 after the next edge and the block returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_req | input | 1 | Host bus request, active high |
| ext_prio | input | PW | Programmable host priority level |
| locked | input | 1 | Host is inside a locked read-modify-write sequence |
| halt | input | 1 | Halt; restricts internal eligibility to refresh |
| busy_in_n | input | 1 | Sampled bus-busy line, low = bus in use |
| int_req | input | N_INT | Internal master requests, one bit each |
| int_prio | input | N_INT*PW | Internal master levels, packed by index |
| ext_grant | output | 1 | Grant toward the host, active high |
| busy_n_out | output | 1 | Bus-busy drive value, low while internal owns |
| busy_oe | output | 1 | Output enable for busy_n_out |
| int_granted | output | N_INT | One-cycle one-hot pulse to the winning internal master |

## Verification
All outputs are decoded from the registers that change at the clock edge where the inputs are sampled, so every result is due one cycle after its stimulus. The host grant, the busy enable and the winner pulse all appear after the first edge that sees the new inputs. A handover from the host adds exactly one more cycle, for the wait state, counted from the edge that samples the released busy line. The bench changes inputs 1 ns after a rising edge and reads outputs 1 ns after the next rising edge. Each expected value therefore matches a known number of edges, and a late or early response shows up as a mismatch.

// File: rtl/arb_pkg.sv
// Shared types for the external bus arbiter.
// Assumes: nothing beyond IEEE 1800-2017 synthesizable constructs.
package arb_pkg;

    // Ownership states of the shared bus.
    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_EXT_OWN  = 2'd1,
        ST_INT_WAIT = 2'd2,
        ST_INT_OWN  = 2'd3
    } arb_state_e;

endpackage

// File: rtl/arb_req_mask.sv
// Eligibility mask for internal requests.
// While halt is high, only the refresh requester stays eligible; all
// other requests are masked off. Assumes REFRESH_IDX < N_INT.
module arb_req_mask #(
    parameter int N_INT       = 3,
    parameter int REFRESH_IDX = 2
) (
    input  logic             halt,
    input  logic [N_INT-1:0] req_in,
    output logic [N_INT-1:0] req_elig
);

    genvar g;
    generate
        for (g = 0; g < N_INT; g++) begin : g_mask
            if (g == REFRESH_IDX) begin : g_refresh
                // Refresh is always eligible.
                assign req_elig[g] = req_in[g];
            end else begin : g_dma
                // DMA sources are blocked while halted.
                assign req_elig[g] = req_in[g] & ~halt;
            end
        end
    endgenerate

endmodule

// File: rtl/arb_prio_pick.sv
// Highest-level selector over eligible internal requests.
// Strict comparison means the lowest index wins among equal levels.
// Assumes level k occupies prio_flat[k*PW +: PW].
module arb_prio_pick #(
    parameter int N_INT = 3,
    parameter int PW    = 3,
    localparam int IW   = (N_INT > 1) ? $clog2(N_INT) : 1
) (
    input  logic [N_INT-1:0]    req_elig,
    input  logic [N_INT*PW-1:0] prio_flat,
    output logic                any_req,
    output logic [IW-1:0]       best_idx,
    output logic [PW-1:0]       best_prio
);

    // Linear scan for the maximum level, lowest index first.
    always_comb begin
        any_req   = 1'b0;
        best_idx  = '0;
        best_prio = '0;
        for (int k = 0; k < N_INT; k++) begin
            if (req_elig[k] && (!any_req || prio_flat[k*PW +: PW] > best_prio)) begin
                any_req   = 1'b1;
                best_idx  = IW'(k);
                best_prio = prio_flat[k*PW +: PW];
            end
        end
    end

endmodule

// File: rtl/arb_fsm.sv
// Ownership state machine for the shared bus.
// Assumes any_int/best_prio describe eligible requests only. Ties with
// the host level favour the present owner; from idle they favour the host.
module arb_fsm #(
    parameter int PW = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ext_req,
    input  logic [PW-1:0]      ext_prio,
    input  logic               locked,
    input  logic               busy_in_n,
    input  logic               any_int,
    input  logic [PW-1:0]      best_prio,
    output arb_pkg::arb_state_e state,
    output logic               take_bus
);
    import arb_pkg::*;

    arb_state_e nxt;
    logic       int_beats_ext;
    logic       ext_beats_int;

    // Strict comparisons in both directions: equal levels never preempt.
    assign int_beats_ext = any_int && (best_prio > ext_prio);
    assign ext_beats_int = ext_req && (!any_int || (ext_prio > best_prio));

    // Next-state selection.
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (any_int && (!ext_req || int_beats_ext)) nxt = ST_INT_WAIT;
                else if (ext_req)                           nxt = ST_EXT_OWN;
            end
            ST_EXT_OWN: begin
                if (int_beats_ext && !locked) nxt = ST_INT_WAIT;
                else if (!ext_req)            nxt = any_int ? ST_INT_WAIT : ST_IDLE;
            end
            ST_INT_WAIT: begin
                if (!any_int)       nxt = ext_req ? ST_EXT_OWN : ST_IDLE;
                else if (busy_in_n) nxt = ST_INT_OWN;
            end
            ST_INT_OWN: begin
                if (ext_beats_int)  nxt = ST_EXT_OWN;
                else if (!any_int)  nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // Entry strobe into internal ownership.
    assign take_bus = (state == ST_INT_WAIT) && (nxt == ST_INT_OWN);

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

endmodule

// File: rtl/arb_bus_drive.sv
// Output stage: grant and busy drive decoded from state, plus the
// one-cycle winner pulse registered on entry to internal ownership.
// Assumes take_bus is a single-cycle strobe from the state machine.
module arb_bus_drive #(
    parameter int N_INT = 3,
    localparam int IW   = (N_INT > 1) ? $clog2(N_INT) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  arb_pkg::arb_state_e state,
    input  logic               take_bus,
    input  logic [IW-1:0]      best_idx,
    output logic               ext_grant,
    output logic               busy_n_out,
    output logic               busy_oe,
    output logic [N_INT-1:0]   int_granted
);
    import arb_pkg::*;

    logic [N_INT-1:0] win_dec;

    // Grant and busy lines come straight from the state register.
    assign ext_grant  = (state == ST_EXT_OWN);
    assign busy_oe    = (state == ST_INT_OWN);
    assign busy_n_out = ~busy_oe;

    genvar g;
    generate
        for (g = 0; g < N_INT; g++) begin : g_dec
            // One-hot decode of the selected winner.
            assign win_dec[g] = (best_idx == IW'(g));
        end
    endgenerate

    // Winner pulse, one cycle, aligned with the first owned cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)        int_granted <= '0;
        else if (take_bus) int_granted <= win_dec;
        else               int_granted <= '0;
    end

endmodule

// File: rtl/ext_bus_arbiter.sv
// Top level: arbitrates one external bus between a host processor and
// N_INT internal masters. Assumes busy_in_n is already synchronous to clk.
module ext_bus_arbiter #(
    parameter int N_INT       = 3,
    parameter int PW          = 3,
    parameter int REFRESH_IDX = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ext_req,
    input  logic [PW-1:0]       ext_prio,
    input  logic                locked,
    input  logic                halt,
    input  logic                busy_in_n,
    input  logic [N_INT-1:0]    int_req,
    input  logic [N_INT*PW-1:0] int_prio,
    output logic                ext_grant,
    output logic                busy_n_out,
    output logic                busy_oe,
    output logic [N_INT-1:0]    int_granted
);
    import arb_pkg::*;

    localparam int IW = (N_INT > 1) ? $clog2(N_INT) : 1;

    logic [N_INT-1:0] req_elig;
    logic             any_int;
    logic [IW-1:0]    best_idx;
    logic [PW-1:0]    best_prio;
    arb_state_e       state;
    logic             take_bus;

    arb_req_mask #(.N_INT(N_INT), .REFRESH_IDX(REFRESH_IDX)) u_mask (
        .halt     (halt),
        .req_in   (int_req),
        .req_elig (req_elig)
    );

    arb_prio_pick #(.N_INT(N_INT), .PW(PW)) u_pick (
        .req_elig  (req_elig),
        .prio_flat (int_prio),
        .any_req   (any_int),
        .best_idx  (best_idx),
        .best_prio (best_prio)
    );

    arb_fsm #(.PW(PW)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .ext_req   (ext_req),
        .ext_prio  (ext_prio),
        .locked    (locked),
        .busy_in_n (busy_in_n),
        .any_int   (any_int),
        .best_prio (best_prio),
        .state     (state),
        .take_bus  (take_bus)
    );

    arb_bus_drive #(.N_INT(N_INT)) u_drive (
        .clk         (clk),
        .rst_n       (rst_n),
        .state       (state),
        .take_bus    (take_bus),
        .best_idx    (best_idx),
        .ext_grant   (ext_grant),
        .busy_n_out  (busy_n_out),
        .busy_oe     (busy_oe),
        .int_granted (int_granted)
    );

endmodule

// File: rtl/arb_checker.sv
// Port-level temporal checks for ext_bus_arbiter, attached by bind.
// Assumes synchronous active-low reset on rst_n.
module arb_checker #(
    parameter int N_INT = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ext_req,
    input logic             locked,
    input logic             busy_in_n,
    input logic             ext_grant,
    input logic             busy_n_out,
    input logic             busy_oe,
    input logic [N_INT-1:0] int_granted
);

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!ext_grant && !busy_oe && int_granted == '0)); // R1

    AST_GRANT_BUSY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(ext_grant && busy_oe)); // R7

    AST_BUSY_LOW_WHEN_ON: assert property (@(posedge clk) disable iff (!rst_n)
        busy_oe |-> !busy_n_out); // R7

    AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_grant && locked && ext_req) |=> ext_grant); // R5

    AST_OWN_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_oe) |-> $past(busy_in_n)); // R6

    AST_NO_DIRECT_HANDOFF: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ext_grant) |-> !busy_oe); // R6

    AST_PULSE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(int_granted)); // R11

    AST_PULSE_ON_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (int_granted != '0) |-> $rose(busy_oe)); // R11

endmodule

bind ext_bus_arbiter arb_checker #(.N_INT(N_INT)) u_arb_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .ext_req     (ext_req),
    .locked      (locked),
    .busy_in_n   (busy_in_n),
    .ext_grant   (ext_grant),
    .busy_n_out  (busy_n_out),
    .busy_oe     (busy_oe),
    .int_granted (int_granted)
);

// File: tb/test_ext_bus_arbiter.sv
`timescale 1ns/1ps
// Directed bench for ext_bus_arbiter: one task per scenario.
module test_ext_bus_arbiter;

    localparam int N_INT = 3;
    localparam int PW    = 3;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                ext_req = 1'b0;
    logic [PW-1:0]       ext_prio = '0;
    logic                locked = 1'b0;
    logic                halt = 1'b0;
    logic                busy_in_n = 1'b1;
    logic [N_INT-1:0]    int_req = '0;
    logic [N_INT*PW-1:0] int_prio = '0;
    logic                ext_grant;
    logic                busy_n_out;
    logic                busy_oe;
    logic [N_INT-1:0]    int_granted;

    int compared   = 0;
    int mismatched = 0;

    always #2 clk = ~clk;

    ext_bus_arbiter #(.N_INT(N_INT), .PW(PW), .REFRESH_IDX(2)) i_ext_bus_arbiter (
        .clk(clk), .rst_n(rst_n), .ext_req(ext_req), .ext_prio(ext_prio),
        .locked(locked), .halt(halt), .busy_in_n(busy_in_n),
        .int_req(int_req), .int_prio(int_prio), .ext_grant(ext_grant),
        .busy_n_out(busy_n_out), .busy_oe(busy_oe), .int_granted(int_granted)
    );

    // Advance one edge; land 1 ns after it to drive and sample.
    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic set_lvl(input int idx, input int lvl);
        int_prio[idx*PW +: PW] = PW'(lvl);
    endtask

    // Return to idle with all inputs quiet.
    task automatic restart();
        ext_req = 0; locked = 0; halt = 0; busy_in_n = 1;
        int_req = '0; int_prio = '0; ext_prio = '0;
        rst_n = 0;
        step();
        rst_n = 1;
    endtask

    task automatic t_reset();
        rst_n = 0;
        step(); step();
        chk("R1 grant", ext_grant, 0);
        chk("R1 oe", busy_oe, 0);
        chk("R1 busy_n", busy_n_out, 1);
        chk("R1 pulse", int_granted, 0);
        rst_n = 1;
    endtask

    task automatic t_host_basic();
        restart();
        ext_req = 1;
        step();
        chk("R2 grant after request", ext_grant, 1);
        step();
        chk("R2 grant held", ext_grant, 1);
        ext_req = 0;
        step();
        chk("R12 grant dropped", ext_grant, 0);
        chk("R12 oe idle", busy_oe, 0);
    endtask

    task automatic t_internal_basic();
        restart();
        busy_in_n = 0;
        set_lvl(0, 3); int_req = 3'b001;
        step();
        chk("R6 wait grant", ext_grant, 0);
        chk("R6 wait oe", busy_oe, 0);
        step();
        chk("R6 held while busy", busy_oe, 0);
        busy_in_n = 1;
        step();
        chk("R7 oe on", busy_oe, 1);
        chk("R7 busy low", busy_n_out, 0);
        chk("R11 pulse", int_granted, 3'b001);
        step();
        chk("R11 pulse one cycle", int_granted, 0);
        chk("R8 persists", busy_oe, 1);
        int_req = '0; ext_req = 1;
        step();
        chk("R8 to host", ext_grant, 1);
        chk("R7 oe off", busy_oe, 0);
    endtask

    task automatic t_simultaneous();
        restart();
        ext_prio = 4; set_lvl(1, 5); int_req = 3'b010; ext_req = 1;
        step();
        chk("R3 higher internal wins", ext_grant, 0);
        step();
        chk("R3 internal owns", busy_oe, 1);
        chk("R3 winner pulse", int_granted, 3'b010);
        restart();
        ext_prio = 4; set_lvl(1, 4); int_req = 3'b010; ext_req = 1;
        step();
        chk("R3 tie to host", ext_grant, 1);
        restart();
        ext_prio = 4; set_lvl(1, 2); int_req = 3'b010; ext_req = 1;
        step();
        chk("R3 host higher", ext_grant, 1);
    endtask

    task automatic t_preempt_host();
        restart();
        ext_prio = 4; ext_req = 1;
        step();
        set_lvl(0, 4); int_req = 3'b001;
        step();
        chk("R4 equal no preempt", ext_grant, 1);
        set_lvl(0, 5);
        step();
        chk("R4 higher preempts", ext_grant, 0);
        step();
        chk("R4 then owns", busy_oe, 1);
    endtask

    task automatic t_locked();
        restart();
        ext_prio = 2; ext_req = 1; locked = 1;
        step();
        set_lvl(0, 6); int_req = 3'b001;
        step();
        chk("R5 locked hold 1", ext_grant, 1);
        step();
        chk("R5 locked hold 2", ext_grant, 1);
        locked = 0;
        step();
        chk("R5 released", ext_grant, 0);
    endtask

    task automatic t_host_takes_back();
        restart();
        set_lvl(0, 3); int_req = 3'b001;
        step(); step();
        chk("R9 internal owns", busy_oe, 1);
        ext_prio = 3; ext_req = 1;
        step();
        chk("R9 tie keeps internal", busy_oe, 1);
        chk("R9 tie no grant", ext_grant, 0);
        ext_prio = 6;
        step();
        chk("R9 host takes over", ext_grant, 1);
        chk("R9 oe released", busy_oe, 0);
    endtask

    task automatic t_halt();
        restart();
        halt = 1; set_lvl(0, 7); int_req = 3'b001;
        step(); step();
        chk("R10 DMA ignored oe", busy_oe, 0);
        chk("R10 DMA ignored pulse", int_granted, 0);
        int_req = 3'b101; set_lvl(2, 1);
        step(); step();
        chk("R10 refresh served", int_granted, 3'b100);
        int_req = 3'b001;
        step();
        chk("R10 release without refresh", busy_oe, 0);
        restart();
        set_lvl(0, 5); int_req = 3'b001;
        step(); step();
        halt = 1; ext_req = 1;
        step();
        chk("R10 halt hands to host", ext_grant, 1);
    endtask

    task automatic t_internal_tie();
        restart();
        set_lvl(0, 5); set_lvl(1, 5); int_req = 3'b011;
        step(); step();
        chk("R11 tie lower index", int_granted, 3'b001);
        restart();
        set_lvl(0, 5); set_lvl(1, 6); int_req = 3'b011;
        step(); step();
        chk("R11 higher level wins", int_granted, 3'b010);
    endtask

    task automatic t_host_leaves_to_int();
        restart();
        ext_prio = 7; ext_req = 1;
        step();
        set_lvl(0, 1); int_req = 3'b001;
        step();
        chk("R4 low internal waits", ext_grant, 1);
        ext_req = 0;
        step();
        chk("R12 drop with internal pending", ext_grant, 0);
        step();
        chk("R8 internal after host", busy_oe, 1);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        #1;
        t_reset();
        t_host_basic();
        t_internal_basic();
        t_simultaneous();
        t_preempt_host();
        t_locked();
        t_host_takes_back();
        t_halt();
        t_internal_tie();
        t_host_leaves_to_int();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule